// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single output line. A write port fills a one-word holding buffer. When transmission is enabled and the buffer holds a word, the word moves into a shift register and a frame goes out. The frame is one low start bit, 7, 8 or 9 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The line rests high between frames.

The bit period is 16×(n+1) ticks of a selectable source. The source is every clock, a fixed divide-by-8 or divide-by-32 of the clock, or an external single-cycle tick input. The value n is an 8-bit input. The buffer empties as soon as its word enters the shift register, so the next word can be written while the current frame is still on the line. If a word is waiting when the last stop bit ends, the next frame follows with no idle gap. A one-cycle interrupt pulse marks one of two points, chosen by an input: the moment the buffer empties, or the end of the last stop bit.

Top module: `sio_tx`

## Requirements
- R1: Out of reset, `txd_o` is 1, `buf_empty_o` is 1 and `irq_o` is 0.
- R2: A frame is a 0 start bit, then the data bits sent LSB first, then parity if enabled, then stop bits at 1. The line is 1 whenever no frame is in progress.
- R3: `parity_i` 2'b00 or 2'b01 sends no parity bit. 2'b10 selects even parity: the data bits and the parity bit together hold an even number of ones. 2'b11 selects odd parity: they hold an odd number of ones.
- R4: `stop2_i` 0 sends one stop bit and 1 sends two stop bits.
- R5: Every bit lasts 16×(`baud_div_i`+1) source ticks. `clk_sel_i` selects the source: 0 is every clock, 1 is every 8th clock, 2 is every 32nd clock, 3 is each cycle in which `ext_tick_i` is high. `char_len_i` sets the data length: 2'b00 is 7 bits, 2'b10 is 9 bits, 2'b01 or 2'b11 is 8 bits.
- R6: A frame starts from idle only when `tx_en_i` is 1 and the buffer is full. With clock source 0, a word written in cycle w drives the start bit on `txd_o` after edge w+2. While `tx_en_i` is 0, a written word stays in the buffer, `buf_empty_o` stays 0 and the line stays high.
- R7: `buf_empty_o` goes to 1 on the edge that moves the word into the shift register. With `irq_sel_i` 0, `irq_o` pulses high for one cycle on that same edge.
- R8: With `irq_sel_i` 1, `irq_o` pulses high for one cycle on the edge that ends the last stop bit. Exactly one pulse is produced per frame.
- R9: If the buffer is full when the last stop bit ends, the next start bit begins on that same edge. Consecutive start bits are then exactly one frame length apart.
- R10: A write sets `buf_empty_o` to 0 on the next edge. A write to a full buffer replaces the waiting word, and only the last word written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 9 | Word to send |
| char_len_i | input | 2 | Data length code |
| parity_i | input | 2 | Parity mode code |
| stop2_i | input | 1 | Two stop bits when set |
| irq_sel_i | input | 1 | Interrupt point: 0 buffer empty, 1 frame end |
| clk_sel_i | input | 2 | Bit-rate source select |
| ext_tick_i | input | 1 | External single-cycle source tick |
| baud_div_i | input | 8 | Divider value n |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Holding buffer empty |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Random words are sent across random data lengths, parity modes, stop counts, interrupt points and small divider values. The random traffic has words written while a frame is in flight, which exercises the double buffer and the frames sent with no gap. Directed cases cover the following, each separating a failure that the random traffic would blur:
- the exact start latency from idle, which tells a missing or extra register stage apart from a correct one;
- the spacing between two frames sent back to back, which tells a correct bit period from an off-by-one divider or an idle gap;
- a write while transmission is disabled, which separates the buffer-full condition from the enable condition;
- an overwrite of a waiting word, which shows the buffer replaces its word rather than queuing it.

One frame is also sent on each of the three slower clock sources.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int unsigned DATA_W = 9;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} tx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       stop2;
  } frame_cfg_t;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    case (code)
      2'b00:   char_bits = 4'd7;
      2'b10:   char_bits = 4'd9;
      default: char_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/sio_tx_srcclk.sv
module sio_tx_srcclk #(
  parameter int unsigned PRE_A = 8,
  parameter int unsigned PRE_B = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);
  logic [1:0] pre_tick;

  for (genvar g = 0; g < 2; g++) begin : g_pre
    localparam int unsigned LIM = (g == 0) ? PRE_A : PRE_B;
    localparam int unsigned CW  = $clog2(LIM + 1);
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (cnt_q == CW'(LIM - 1)) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
    assign pre_tick[g] = (cnt_q == CW'(LIM - 1));
  end

  always_comb begin
    case (sel_i)
      2'd0:    tick_o = 1'b1;
      2'd1:    tick_o = pre_tick[0];
      2'd2:    tick_o = pre_tick[1];
      default: tick_o = ext_tick_i;
    endcase
  end
endmodule

// File: rtl/sio_tx_baud.sv
module sio_tx_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_tick_o
);
  localparam int unsigned CW = DIV_W + OVS_W;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  // (n+1)*2^OVS_W - 1
  assign lim        = {div_i, {OVS_W{1'b1}}};
  assign bit_tick_o = src_tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (bit_tick_o) cnt_q <= '0;
    else if (src_tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx_frame.sv
module sio_tx_frame
  import sio_tx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          full_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    char_len_i,
  input  logic [1:0]    parity_i,
  input  logic          stop2_i,
  input  logic          irq_sel_i,
  input  logic          bit_tick_i,
  output logic          take_o,
  output logic          div_clr_o,
  output logic          busy_o,
  output logic          txd_o,
  output logic          irq_o
);
  tx_state_e     state_q;
  logic [DW-1:0] sr_q;
  logic [3:0]    bit_cnt_q;
  logic          stop_cnt_q;
  logic          par_q;
  frame_cfg_t    cfg_q, cfg_new;
  logic [DW-1:0] mask;
  logic          par_new, last_data, last_stop, frame_end, load;

  always_comb begin
    cfg_new.nbits  = char_bits(char_len_i);
    cfg_new.par_en = parity_i[1];
    cfg_new.stop2  = stop2_i;
    for (int i = 0; i < DW; i++) mask[i] = (4'(i) < cfg_new.nbits);
    par_new = (^(data_i & mask)) ^ parity_i[0];
  end

  assign last_data = (bit_cnt_q == cfg_q.nbits - 4'd1);
  assign last_stop = (stop_cnt_q == cfg_q.stop2);
  assign frame_end = (state_q == ST_STOP) && bit_tick_i && last_stop;
  assign load      = tx_en_i && full_i && ((state_q == ST_IDLE) || frame_end);
  assign take_o    = load;
  assign div_clr_o = (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sr_q       <= '0;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      par_q      <= 1'b0;
      cfg_q      <= '0;
      txd_o      <= 1'b1;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= (load && !irq_sel_i) || (frame_end && irq_sel_i);
      if (load) begin
        state_q    <= ST_START;
        sr_q       <= data_i;
        cfg_q      <= cfg_new;
        par_q      <= par_new;
        bit_cnt_q  <= '0;
        stop_cnt_q <= 1'b0;
        txd_o      <= 1'b0;
      end else if (bit_tick_i) begin
        case (state_q)
          ST_START: begin
            state_q   <= ST_DATA;
            txd_o     <= sr_q[0];
            sr_q      <= sr_q >> 1;
            bit_cnt_q <= '0;
          end
          ST_DATA: begin
            if (last_data) begin
              if (cfg_q.par_en) begin
                state_q <= ST_PAR;
                txd_o   <= par_q;
              end else begin
                state_q    <= ST_STOP;
                txd_o      <= 1'b1;
                stop_cnt_q <= 1'b0;
              end
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
              txd_o     <= sr_q[0];
              sr_q      <= sr_q >> 1;
            end
          end
          ST_PAR: begin
            state_q    <= ST_STOP;
            txd_o      <= 1'b1;
            stop_cnt_q <= 1'b0;
          end
          ST_STOP: begin
            if (last_stop) begin
              state_q <= ST_IDLE;
              txd_o   <= 1'b1;
            end else begin
              stop_cnt_q <= 1'b1;
            end
          end
          default: begin
            state_q <= ST_IDLE;
            txd_o   <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS_W = 4,
  parameter int unsigned PRE_A = 8,
  parameter int unsigned PRE_B = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]       char_len_i,
  input  logic [1:0]       parity_i,
  input  logic             stop2_i,
  input  logic             irq_sel_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             ext_tick_i,
  input  logic [DIV_W-1:0] baud_div_i,
  output logic             txd_o,
  output logic             buf_empty_o,
  output logic             irq_o
);
  logic              src_tick, bit_tick, div_clr, take, full, busy;
  logic [DATA_W-1:0] buf_data;

  sio_tx_srcclk #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(clk_sel_i),
    .ext_tick_i(ext_tick_i), .tick_o(src_tick)
  );

  sio_tx_baud #(.DIV_W(DIV_W), .OVS_W(OVS_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(div_clr), .src_tick_i(src_tick),
    .div_i(baud_div_i), .bit_tick_o(bit_tick)
  );

  sio_tx_hold #(.DW(DATA_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .take_i(take), .full_o(full), .data_o(buf_data)
  );

  sio_tx_frame #(.DW(DATA_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .full_i(full),
    .data_i(buf_data), .char_len_i(char_len_i), .parity_i(parity_i),
    .stop2_i(stop2_i), .irq_sel_i(irq_sel_i), .bit_tick_i(bit_tick),
    .take_o(take), .div_clr_o(div_clr), .busy_o(busy), .txd_o(txd_o),
    .irq_o(irq_o)
  );

  assign buf_empty_o = !full;
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic tx_en_i,
  input logic busy_i,
  input logic txd_i,
  input logic buf_empty_i,
  input logic irq_i
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_i); // R2

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !txd_i); // R2

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(tx_en_i) && !$past(buf_empty_i))); // R6

  AST_LOAD_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !$past(wr_i)) |-> buf_empty_i); // R7

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R8

  AST_WR_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !buf_empty_i); // R10

  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && buf_empty_i) |=> buf_empty_i); // R10
endmodule

bind sio_tx sio_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .tx_en_i(tx_en_i),
  .busy_i(busy), .txd_i(txd_o), .buf_empty_i(buf_empty_o), .irq_i(irq_o)
);

// File: tb/tb_sio_tx.sv
module tb_sio_tx;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_K = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, wr = 1'b0, ext_tick = 1'b0;
  logic [8:0] wdata = '0;
  logic [1:0] c_len = 2'b01, c_par = 2'b00, c_src = 2'd0;
  logic       c_stop2 = 1'b0, c_irq = 1'b0;
  logic [7:0] c_n = 8'd0;
  logic       txd, buf_empty, irq;

  int cyc = 0, n_chk = 0, n_fail = 0, frames = 0, irq_cnt = 0;
  logic [8:0] exp_q[$];
  int start_q[$];

  sio_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .wr_i(wr), .wr_data_i(wdata),
    .char_len_i(c_len), .parity_i(c_par), .stop2_i(c_stop2), .irq_sel_i(c_irq),
    .clk_sel_i(c_src), .ext_tick_i(ext_tick), .baud_div_i(c_n),
    .txd_o(txd), .buf_empty_o(buf_empty), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && irq === 1'b1) irq_cnt++;

  initial begin
    int e = 0;
    forever begin
      @(negedge clk);
      ext_tick = (e == EXT_K - 1);
      e = (e + 1) % EXT_K;
    end
  end

  function automatic int nbits(input logic [1:0] code);
    return (code == 2'b00) ? 7 : (code == 2'b10) ? 9 : 8;
  endfunction

  function automatic int period();
    int k;
    k = (c_src == 0) ? 1 : (c_src == 1) ? 8 : (c_src == 2) ? 32 : EXT_K;
    return 16 * (int'(c_n) + 1) * k;
  endfunction

  function automatic int flen();
    return 1 + nbits(c_len) + (c_par[1] ? 1 : 0) + (c_stop2 ? 2 : 1);
  endfunction

  function automatic logic exp_par(input logic [8:0] d, input int l, input logic odd);
    logic p = odd;
    for (int i = 0; i < l; i++) p ^= d[i];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Frame monitor: samples each bit at its midpoint
  initial begin
    @(posedge rst_n);
    forever begin
      int t0, p, l;
      logic [8:0] w, got;
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      start_q.push_back(t0);
      p = period();
      l = nbits(c_len);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected frame", 1, 0);
        w = '0;
      end else w = exp_q.pop_front();
      if (!c_irq) chk(irq === 1'b1, "R7 irq at load", int'(irq), 1);
      repeat (p/2) @(negedge clk);
      chk(txd === 1'b0, "R2 start bit", int'(txd), 0);
      got = '0;
      for (int i = 0; i < l; i++) begin
        repeat (p) @(negedge clk);
        got[i] = txd;
      end
      chk((got & ((9'd1 << l) - 9'd1)) == (w & ((9'd1 << l) - 9'd1)),
          (c_src == 0) ? "R2 data LSB first" : "R5 data at slow source",
          int'(got), int'(w & ((9'd1 << l) - 9'd1)));
      if (c_par[1]) begin
        repeat (p) @(negedge clk);
        chk(txd === exp_par(w, l, c_par[0]), "R3 parity bit", int'(txd),
            int'(exp_par(w, l, c_par[0])));
      end
      for (int s = 0; s < (c_stop2 ? 2 : 1); s++) begin
        repeat (p) @(negedge clk);
        chk(txd === 1'b1, "R4 stop bit", int'(txd), 1);
      end
      repeat (p/2) @(negedge clk);
      if (c_irq && c_src == 0) chk(irq === 1'b1, "R8 irq at frame end", int'(irq), 1);
      frames++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    report();
  end

  task automatic put(input logic [8:0] d);
    wdata = d; wr = 1'b1; exp_q.push_back(d);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_frames(input int t);
    while (frames < t) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int w, base, f;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd reset", int'(txd), 1);
    chk(buf_empty === 1'b1, "R1 buf_empty reset", int'(buf_empty), 1);
    chk(irq === 1'b0, "R1 irq reset", int'(irq), 0);

    // R6: start latency from idle
    tx_en = 1'b1; c_len = 2'b01; c_par = 2'b00; c_stop2 = 1'b0; c_irq = 1'b0; c_n = 8'd0;
    start_q.delete();
    w = cyc;
    put(9'h0A5);
    wait_frames(1);
    chk(start_q[0] == w + 2, "R6 start latency", start_q[0], w + 2);

    // R9/R5: back-to-back spacing, R8 irq at end, 9 bits even parity, 2 stops
    c_irq = 1'b1; c_n = 8'd1; c_len = 2'b10; c_par = 2'b10; c_stop2 = 1'b1;
    start_q.delete();
    put(9'h1C3);
    while (buf_empty !== 1'b1) @(negedge clk);
    put(9'h03C);
    wait_frames(3);
    f = flen() * period();
    chk(start_q.size() == 2 && start_q[1] - start_q[0] == f,
        "R9 R5 frame spacing", start_q[1] - start_q[0], f);

    // R6: disabled transmitter keeps word waiting
    tx_en = 1'b0; c_irq = 1'b0; c_len = 2'b00; c_par = 2'b11; c_stop2 = 1'b0; c_n = 8'd0;
    base = frames;
    put(9'h055);
    repeat (100) @(negedge clk);
    chk(txd === 1'b1, "R6 line idle while disabled", int'(txd), 1);
    chk(buf_empty === 1'b0, "R6 word held while disabled", int'(buf_empty), 0);
    chk(frames == base, "R6 no frame while disabled", frames, base);
    tx_en = 1'b1;
    wait_frames(base + 1);

    // R10: overwrite of waiting word
    c_len = 2'b01; c_par = 2'b10;
    base = frames;
    put(9'h011);
    while (buf_empty !== 1'b1) @(negedge clk);
    wdata = 9'h0EE; wr = 1'b1;
    @(negedge clk); wdata = 9'h077;
    @(negedge clk); wr = 1'b0;
    chk(buf_empty === 1'b0, "R10 write fills buffer", int'(buf_empty), 0);
    exp_q.push_back(9'h077);
    wait_frames(base + 2);
    chk(exp_q.size() == 0, "R10 only last word sent", exp_q.size(), 0);

    // R5: slower sources
    for (int s = 1; s < 4; s++) begin
      c_src = 2'(s); c_len = 2'b00; c_par = 2'b11; c_stop2 = 1'b1; c_n = 8'd0;
      base = frames;
      put(9'(9'h02B + s));
      wait_frames(base + 1);
    end
    c_src = 2'd0;

    // Random traffic
    for (int g = 0; g < 8; g++) begin
      c_len = 2'($urandom % 4); c_par = 2'($urandom % 4);
      c_stop2 = 1'($urandom % 2); c_irq = 1'($urandom % 2); c_n = 8'($urandom % 4);
      base = frames;
      for (int k = 0; k < 5; k++) begin
        while (buf_empty !== 1'b1) @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
        put(9'($urandom));
      end
      wait_frames(base + 5);
    end

    repeat (4) @(negedge clk);
    chk(irq_cnt == frames, "R7 R8 one irq per frame", irq_cnt, frames);
    chk(exp_q.size() == 0, "R2 all words sent", exp_q.size(), 0);
    report();
  end
endmodule